// File: doc/BRIEF.md
# Byte-Lane RAM Port with Selectable Collision Mode

This block is a single-port synchronous RAM. One port enable gates all activity; a write-enable vector with one bit per 8-bit lane chooses which bytes of the addressed word are overwritten on a clock edge. Read data comes out of a register one edge after the access.

A parameter fixes how the read register behaves when a write and a read hit the same edge. In read-first mode the register captures the word as it stood before the edge. In write-first mode the write is applied ahead of the read, so the register captures the freshly written bytes merged with the untouched ones. In no-change mode any active byte write suppresses the read, and the register keeps whatever it last held. The array can optionally start filled with zeros.

Top module: `bytelane_ram`

## Requirements
- R1: `DATA_W` is a multiple of 8 and the write-enable vector has `DATA_W/8` bits; write-enable bit i controls data bits [8i+7:8i].
- R2: While `rstN` is low the read-data register is 0.
- R3: On an edge with `en` high, byte lane i of the addressed word takes the new data exactly when `we[i]` is 1; lanes with `we[i]` 0 keep their stored bytes.
- R4: With `en` low nothing is written and nothing is read; `rdata` keeps its value.
- R5: With `MODE` = write-first (encoding 1), an edge with `en` high loads `rdata` with the new bytes in written lanes and the stored bytes in the other lanes.
- R6: With `MODE` = read-first (encoding 0), an edge with `en` high loads `rdata` with the word as it was before that edge's write.
- R7: With `MODE` = no-change (encoding 2), an edge with `en` high and any `we` bit set leaves `rdata` unchanged, while the write itself still happens.
- R8: In every mode, an edge with `en` high and `we` all zero loads `rdata` with the stored word at `addr`.
- R9: With `INIT_ZERO` set, every word reads as 0 before it is first written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all accesses on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the read register |
| en | input | 1 | Port enable for both read and write |
| we | input | DATA_W/8 | Per-lane write enable |
| addr | input | $clog2(DEPTH) | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |

## Verification
The bench drives identical traffic into one instance of each mode, so a collision edge shows the three answers side by side: a read-first port that forwarded new data, a write-first port that returned stale bytes, or a no-change port that updated its register would each differ from the computed value. A partial lane mask checks lane placement, catching a design that writes the wrong byte or lets a forwarded lane leak into an unwritten one. Disabled edges carrying a full write mask follow, then a plain read of the same word, to catch a design that writes or reads while the port enable is low.

// File: rtl/bytelane_ram_pkg.sv
package bytelane_ram_pkg;

  typedef enum logic [1:0] {
    WM_READ_FIRST  = 2'd0,
    WM_WRITE_FIRST = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wrmode_e;

  typedef struct packed {
    logic readEn;      // capture a word into the read register
    logic forwardNew;  // written lanes bypass storage into the read word
  } strobes_t;

endpackage

// File: rtl/bytelane_ram_ctrl.sv
module bytelane_ram_ctrl
  import bytelane_ram_pkg::*;
#(
  parameter int      LANES = 4,
  parameter wrmode_e MODE  = WM_READ_FIRST
) (
  input  logic             en,
  input  logic [LANES-1:0] we,
  output logic [LANES-1:0] laneWrite,
  output strobes_t         strb
);

  logic anyWrite;

  always_comb begin
    anyWrite        = en && (|we);
    laneWrite       = en ? we : '0;
    strb.readEn     = en && !((MODE == WM_NO_CHANGE) && anyWrite);
    strb.forwardNew = (MODE == WM_WRITE_FIRST);
  end

endmodule

// File: rtl/bytelane_ram_dp.sv
module bytelane_ram_dp
  import bytelane_ram_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 64,
  parameter bit INIT_ZERO = 1'b1,
  localparam int LANES    = DATA_W / 8,
  localparam int ADDR_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LANES-1:0]  laneWrite,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] storage [DEPTH];
  logic [DATA_W-1:0] stored;
  logic [DATA_W-1:0] readWord;

  generate
    if (INIT_ZERO) begin : g_zeroFill
      initial begin
        for (int w = 0; w < DEPTH; w++) storage[w] = '0;
      end
    end
  endgenerate

  assign stored = storage[addr];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (laneWrite[l]) storage[addr][l*8 +: 8] <= wdata[l*8 +: 8];
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      readWord[l*8 +: 8] = (strb.forwardNew && laneWrite[l]) ? wdata[l*8 +: 8]
                                                             : stored[l*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdata <= '0;
    else if (strb.readEn) rdata <= readWord;
  end

endmodule

// File: rtl/bytelane_ram.sv
module bytelane_ram
  import bytelane_ram_pkg::*;
#(
  parameter int      DATA_W    = 32,
  parameter int      DEPTH     = 64,
  parameter wrmode_e MODE      = WM_READ_FIRST,
  parameter bit      INIT_ZERO = 1'b1,
  localparam int     LANES     = DATA_W / 8,
  localparam int     ADDR_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic [LANES-1:0]  we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [LANES-1:0] laneWrite;
  strobes_t         strb;

  bytelane_ram_ctrl #(.LANES(LANES), .MODE(MODE)) u_ctrl (
    .en(en), .we(we), .laneWrite(laneWrite), .strb(strb)
  );

  bytelane_ram_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH), .INIT_ZERO(INIT_ZERO)) u_dp (
    .clk(clk), .rstN(rstN), .laneWrite(laneWrite), .strb(strb),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

endmodule

// File: rtl/bytelane_ram_chk.sv
module bytelane_ram_chk
  import bytelane_ram_pkg::*;
#(
  parameter int      DATA_W = 32,
  parameter int      ADDR_W = 6,
  parameter wrmode_e MODE   = WM_READ_FIRST,
  localparam int     LANES  = DATA_W / 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              en,
  input logic [LANES-1:0]  we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata
);

  // R2
  a_r2_reset_clear: assert property (@(posedge clk) !rstN |=> rdata == '0);

  // R4
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> $stable(rdata));

  // R7
  a_r7_nochange_hold: assert property (@(posedge clk) disable iff (!rstN)
    (MODE == WM_NO_CHANGE) && en && (|we) |=> $stable(rdata));

  // R5
  a_r5_forward_full: assert property (@(posedge clk) disable iff (!rstN)
    (MODE == WM_WRITE_FIRST) && en && (&we) |=> rdata == $past(wdata));

  // R3, R8: full write then plain read of the same word returns it
  a_r3_write_read_back: assert property (@(posedge clk) disable iff (!rstN)
    en && (we == '0) && $past(en) && (&$past(we)) && (addr == $past(addr)) && $past(rstN)
    |=> rdata == $past(wdata, 2));

endmodule

bind bytelane_ram bytelane_ram_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE(MODE)) u_chk (
  .clk(clk), .rstN(rstN), .en(en), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata)
);

// File: tb/bytelane_ram_test.sv
`timescale 1ns/1ps
module bytelane_ram_test;
  import bytelane_ram_pkg::*;

  localparam int DATA_W = 32;
  localparam int DEPTH  = 64;
  localparam int LANES  = DATA_W / 8;
  localparam int ADDR_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic en = 1'b0;
  logic [LANES-1:0]  we = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdRf, rdWf, rdNc;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bytelane_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .MODE(WM_READ_FIRST)) uut (
    .clk(clk), .rstN(rstN), .en(en), .we(we), .addr(addr), .wdata(wdata), .rdata(rdRf));
  bytelane_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .MODE(WM_WRITE_FIRST)) uutWf (
    .clk(clk), .rstN(rstN), .en(en), .we(we), .addr(addr), .wdata(wdata), .rdata(rdWf));
  bytelane_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .MODE(WM_NO_CHANGE)) uutNc (
    .clk(clk), .rstN(rstN), .en(en), .we(we), .addr(addr), .wdata(wdata), .rdata(rdNc));

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] oldW,
      input logic [DATA_W-1:0] newW, input logic [LANES-1:0] mask);
    logic [DATA_W-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*8 +: 8] = mask[l] ? newW[l*8 +: 8] : oldW[l*8 +: 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; applies one access and returns at the next falling edge.
  task automatic access(input logic e, input logic [LANES-1:0] w,
      input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    en = e; we = w; addr = a; wdata = d;
    @(negedge clk);
    en = 1'b0; we = '0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R2 reset rf", rdRf, '0);
    check("R2 reset wf", rdWf, '0);
    check("R2 reset nc", rdNc, '0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_zeroFill;
    access(1'b1, '0, 6'd5, 32'hFFFF_FFFF);
    check("R9 zero fill rf", rdRf, '0);
    check("R9 zero fill nc", rdNc, '0);
  endtask

  task automatic t_plainRead;
    access(1'b1, 4'hF, 6'd1, 32'h1122_3344);
    access(1'b1, 4'h0, 6'd1, 32'h0);
    check("R8 read rf", rdRf, 32'h1122_3344);
    check("R8 read wf", rdWf, 32'h1122_3344);
    check("R8 read nc", rdNc, 32'h1122_3344);
  endtask

  task automatic t_collisionFull;
    access(1'b1, 4'hF, 6'd3, 32'hA0A1_A2A3);
    check("R6 read-first old word", rdRf, '0);
    check("R5 write-first new word", rdWf, 32'hA0A1_A2A3);
    check("R7 no-change hold", rdNc, 32'h1122_3344);
    access(1'b1, 4'h0, 6'd3, 32'h0);
    check("R7 write still done", rdNc, 32'hA0A1_A2A3);
    check("R3 full write rf", rdRf, 32'hA0A1_A2A3);
  endtask

  task automatic t_collisionPartial;
    logic [DATA_W-1:0] expW;
    expW = merge(32'hA0A1_A2A3, 32'hB0B1_B2B3, 4'b0101);
    access(1'b1, 4'b0101, 6'd3, 32'hB0B1_B2B3);
    check("R5 partial forward merge", rdWf, expW);
    check("R6 partial read-first old", rdRf, 32'hA0A1_A2A3);
    check("R7 partial no-change hold", rdNc, 32'hA0A1_A2A3);
    access(1'b1, 4'h0, 6'd3, 32'h0);
    check("R1 lane placement rf", rdRf, expW);
    check("R3 partial lanes nc", rdNc, expW);
  endtask

  task automatic t_disabled;
    logic [DATA_W-1:0] expW;
    expW = merge(32'hA0A1_A2A3, 32'hB0B1_B2B3, 4'b0101);
    access(1'b0, 4'hF, 6'd3, 32'hC0C1_C2C3);
    check("R4 disabled hold rf", rdRf, expW);
    check("R4 disabled hold wf", rdWf, expW);
    access(1'b0, 4'h0, 6'd1, 32'h0);
    check("R4 disabled no read", rdRf, expW);
    access(1'b1, 4'h0, 6'd3, 32'h0);
    check("R4 disabled no write rf", rdRf, expW);
    check("R4 disabled no write nc", rdNc, expW);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_zeroFill();
    t_plainRead();
    t_collisionFull();
    t_collisionPartial();
    t_disabled();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule